// File: doc/BRIEF.md
# Packed Integer Dot-Product Unit

This block is a pipelined SIMD datapath that performs packed integer dot-product accumulation across a wide vector. It takes two source vectors and one accumulator vector of equal width. Each accumulator lane receives a four-way reduction of narrow element products in a single operation. It does not produce one product per element. In byte mode every 32-bit lane pairs four 8-bit elements from each source, multiplies the pairs, sums the four products and adds the sum to the 32-bit accumulator lane. In halfword mode every 64-bit lane does the same with four 16-bit element pairs.

A per-lane enable mask can leave any lane at its accumulator value. A single control bit selects whether both sources are read as two's-complement or as unsigned. Operations enter through a valid/ready handshake and leave through another one after a fixed three-cycle latency. When the consumer is always ready, the unit accepts a new operation on every cycle. Back-pressure freezes the whole pipe without losing or repeating an operation.

The vector is built from 64-bit regions, and `NUM_REGIONS` sets how many there are. The default of 8 gives 512-bit vectors, sixteen 32-bit lanes in byte mode and eight 64-bit lanes in halfword mode.

Top module: `pkdot_unit`

## Requirements
- R1: With `in_wide`=0, result bits [32i+31:32i] equal accumulator lane i plus the sum over j=0..3 of the product of the bytes at bits [32i+8j+7:32i+8j] of `in_a` and `in_b`.
- R2: With `in_wide`=1, result bits [64k+63:64k] equal accumulator lane k plus the sum over j=0..3 of the product of the halfwords at bits [64k+16j+15:64k+16j] of `in_a` and `in_b`.
- R3: With `in_signed`=1, both sources are read as two's-complement elements, and with `in_signed`=0 they are read as unsigned. Each product is extended to the lane width before the sum is taken.
- R4: Accumulation wraps modulo 2^32 per lane in byte mode and modulo 2^64 per lane in halfword mode, with no saturation. No carry passes from one lane into the next.
- R5: Mask bit i enables byte-mode lane i. Mask bit k enables halfword-mode lane k, and mask bits at positions NUM_REGIONS and above have no effect in halfword mode. A disabled lane returns its accumulator value unchanged.
- R6: While `out_ready` is held high, `out_valid` for an operation is high exactly three cycles after the cycle in which `in_valid` and `in_ready` were both high.
- R7: While `out_ready` is held high, `in_ready` stays high, so one operation is accepted per cycle and results leave in acceptance order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_res` hold and `in_ready` is low. Every accepted operation produces exactly one result.
- R9: While `rst_n` is low, `out_valid` and `in_ready` are low. `in_ready` stays low until the second rising clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the unit releases it on the clock |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted when high together with `in_valid` |
| in_wide | input | 1 | 0: byte elements into 32-bit lanes; 1: halfword elements into 64-bit lanes |
| in_signed | input | 1 | 1: two's-complement elements; 0: unsigned elements |
| in_mask | input | 2*NUM_REGIONS | Per-lane enable |
| in_a | input | 64*NUM_REGIONS | First source vector |
| in_b | input | 64*NUM_REGIONS | Second source vector |
| in_acc | input | 64*NUM_REGIONS | Accumulator vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result when high with `out_valid` |
| out_res | output | 64*NUM_REGIONS | Result vector |

## Verification
The bench drives both element sizes and both signedness settings with the extreme element values 0, 1, the largest positive, the most negative and all ones. A design that swapped sign- and zero-extension, or left the products at element width, would return wrong sums exactly on these values. Accumulators are placed at the edge of their range so that a saturating adder or a carry leaking into the next lane would show up as a changed neighbour. Mask sweeps include halfword operations whose only set bits are the ignored upper ones, which catches a lane updated against its mask. Random back-pressure then checks that a stalled result neither changes nor disappears, and a phase with the consumer always ready checks the three-cycle latency and the one-per-cycle acceptance.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int REGION_W  = 64;
  localparam int BYTE_W    = 8;
  localparam int HALF_W    = 16;
  localparam int NBYTE     = REGION_W / BYTE_W;   // byte elements per region
  localparam int NHALF     = REGION_W / HALF_W;   // halfword elements per region
  localparam int NARROW_W  = 32;                  // byte-mode lane width
  localparam int PROD_W    = NBYTE * NARROW_W;    // product bits per region
  localparam int GROUP     = 4;                   // products per lane

  typedef enum logic {ELEM_BYTE = 1'b0, ELEM_HALF = 1'b1} elem_e;
endpackage

// File: rtl/dp_prod_region.sv
module dp_prod_region
  import dp_pkg::*;
(
  input  logic [REGION_W-1:0] opa,
  input  logic [REGION_W-1:0] opb,
  input  elem_e               esz,
  input  logic                sgn,
  output logic [PROD_W-1:0]   prod
);
  localparam int BP_W = 2 * (BYTE_W + 1);
  localparam int HP_W = 2 * (HALF_W + 1);

  logic signed [BP_W-1:0] bprod [NBYTE];
  logic signed [HP_W-1:0] hprod [NHALF];

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    logic signed [BYTE_W:0] xa, xb;
    assign xa = {sgn & opa[BYTE_W*g+BYTE_W-1], opa[BYTE_W*g +: BYTE_W]};
    assign xb = {sgn & opb[BYTE_W*g+BYTE_W-1], opb[BYTE_W*g +: BYTE_W]};
    assign bprod[g] = xa * xb;
  end

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    logic signed [HALF_W:0] xa, xb;
    assign xa = {sgn & opa[HALF_W*g+HALF_W-1], opa[HALF_W*g +: HALF_W]};
    assign xb = {sgn & opb[HALF_W*g+HALF_W-1], opb[HALF_W*g +: HALF_W]};
    assign hprod[g] = xa * xb;
  end

  always_comb begin
    prod = '0;
    if (esz == ELEM_HALF) begin
      for (int j = 0; j < NHALF; j++)
        prod[REGION_W*j +: REGION_W] = {{(REGION_W-HP_W){hprod[j][HP_W-1]}}, hprod[j]};
    end else begin
      for (int i = 0; i < NBYTE; i++)
        prod[NARROW_W*i +: NARROW_W] = {{(NARROW_W-BP_W){bprod[i][BP_W-1]}}, bprod[i]};
    end
  end
endmodule

// File: rtl/dp_reduce_region.sv
module dp_reduce_region
  import dp_pkg::*;
(
  input  logic [PROD_W-1:0]   prod,
  input  elem_e               esz,
  output logic [REGION_W-1:0] sum
);
  always_comb begin
    sum = '0;
    if (esz == ELEM_HALF) begin
      for (int j = 0; j < GROUP; j++)
        sum = sum + prod[REGION_W*j +: REGION_W];
    end else begin
      for (int l = 0; l < REGION_W / NARROW_W; l++)
        for (int j = 0; j < GROUP; j++)
          sum[NARROW_W*l +: NARROW_W] = sum[NARROW_W*l +: NARROW_W]
                                        + prod[NARROW_W*(GROUP*l+j) +: NARROW_W];
    end
  end
endmodule

// File: rtl/dp_acc_region.sv
module dp_acc_region
  import dp_pkg::*;
(
  input  logic [REGION_W-1:0] sum,
  input  logic [REGION_W-1:0] acc,
  input  elem_e               esz,
  input  logic [1:0]          msk,
  output logic [REGION_W-1:0] res
);
  always_comb begin
    res = acc;
    if (esz == ELEM_HALF) begin
      if (msk[0]) res = acc + sum;
    end else begin
      for (int l = 0; l < 2; l++)
        if (msk[l])
          res[NARROW_W*l +: NARROW_W] = acc[NARROW_W*l +: NARROW_W] + sum[NARROW_W*l +: NARROW_W];
    end
  end
endmodule

// File: rtl/pkdot_unit.sv
module pkdot_unit
  import dp_pkg::*;
#(
  parameter  int NUM_REGIONS = 8,
  localparam int VEC_W       = NUM_REGIONS * REGION_W,
  localparam int MASK_W      = 2 * NUM_REGIONS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_wide,
  input  logic              in_signed,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [VEC_W-1:0]  in_a,
  input  logic [VEC_W-1:0]  in_b,
  input  logic [VEC_W-1:0]  in_acc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_res
);
  localparam int PV_W = NUM_REGIONS * PROD_W;

  // reset release synchronizer
  logic [1:0] srst_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 2'b00;
    else        srst_q <= {srst_q[0], 1'b1};
  end
  assign srst_n = srst_q[1];

  // pipeline state
  logic              s1_valid, s2_valid, s3_valid;
  logic              s1_valid_d, s2_valid_d, s3_valid_d;
  elem_e             s1_esz, s2_esz;
  logic [PV_W-1:0]   s1_prod;
  logic [VEC_W-1:0]  s1_acc, s2_acc, s2_sum, s3_res;
  logic [MASK_W-1:0] s1_msk, s2_msk;

  logic              adv, take, s1_en, s2_en, s3_en;
  elem_e             in_esz;
  logic [PV_W-1:0]   prod_d;
  logic [VEC_W-1:0]  sum_d, res_d;
  logic [MASK_W-1:0] msk_d;

  assign in_esz   = elem_e'(in_wide);
  assign adv      = out_ready | ~s3_valid;
  assign in_ready = adv & srst_n;
  assign take     = in_valid & in_ready;
  assign s1_en    = adv & take;
  assign s2_en    = adv & s1_valid;
  assign s3_en    = adv & s2_valid;

  // per-region datapath
  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_region
    assign msk_d[2*k +: 2] = in_wide ? {2{in_mask[k]}} : in_mask[2*k +: 2];

    dp_prod_region u_prod (
      .opa  (in_a[REGION_W*k +: REGION_W]),
      .opb  (in_b[REGION_W*k +: REGION_W]),
      .esz  (in_esz),
      .sgn  (in_signed),
      .prod (prod_d[PROD_W*k +: PROD_W])
    );

    dp_reduce_region u_red (
      .prod (s1_prod[PROD_W*k +: PROD_W]),
      .esz  (s1_esz),
      .sum  (sum_d[REGION_W*k +: REGION_W])
    );

    dp_acc_region u_acc (
      .sum  (s2_sum[REGION_W*k +: REGION_W]),
      .acc  (s2_acc[REGION_W*k +: REGION_W]),
      .esz  (s2_esz),
      .msk  (s2_msk[2*k +: 2]),
      .res  (res_d[REGION_W*k +: REGION_W])
    );
  end

  // valid next-state
  always_comb begin
    s1_valid_d = s1_valid;
    s2_valid_d = s2_valid;
    s3_valid_d = s3_valid;
    if (adv) begin
      s1_valid_d = take;
      s2_valid_d = s1_valid;
      s3_valid_d = s2_valid;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s3_valid <= 1'b0;
    end else begin
      s1_valid <= s1_valid_d;
      s2_valid <= s2_valid_d;
      s3_valid <= s3_valid_d;
    end
  end

  // data registers, enabled per stage
  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_esz  <= in_esz;
      s1_prod <= prod_d;
      s1_acc  <= in_acc;
      s1_msk  <= msk_d;
    end
    if (s2_en) begin
      s2_esz  <= s1_esz;
      s2_sum  <= sum_d;
      s2_acc  <= s1_acc;
      s2_msk  <= s1_msk;
    end
    if (s3_en) begin
      s3_res  <= res_d;
    end
  end

  assign out_valid = s3_valid;
  assign out_res   = s3_res;

  // checks
  AST_ACCEPT_ENTERS: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready) |=> s1_valid) else $error("accepted op not in stage 1"); // R6
  AST_STAGE2_ENTERS: assert property (@(posedge clk) disable iff (!srst_n)
    (s1_valid && out_ready) |=> s2_valid) else $error("stage 1 op lost"); // R6
  AST_STAGE3_ENTERS: assert property (@(posedge clk) disable iff (!srst_n)
    (s2_valid && out_ready) |=> out_valid) else $error("stage 2 op lost"); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res))) else $error("stalled result moved"); // R8
  AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!srst_n)
    (s3_en && (s2_msk == '0)) |=> (out_res == $past(s2_acc))) else $error("masked op changed acc"); // R5
endmodule

// File: tb/pkdot_unit_test.sv
`timescale 1ns/1ps
module pkdot_unit_test;
  localparam int NR = 2;
  localparam int VW = 64 * NR;
  localparam int MW = 2 * NR;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, in_wide, in_signed;
  logic [MW-1:0] in_mask;
  logic [VW-1:0] in_a, in_b, in_acc;
  logic          out_valid, out_ready;
  logic [VW-1:0] out_res;

  pkdot_unit #(.NUM_REGIONS(NR)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_wide(in_wide), .in_signed(in_signed), .in_mask(in_mask),
    .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // expectation queue
  logic [VW-1:0] exp_q [64];
  int            acyc_q [64];
  string         tag_q [64];
  int            wr = 0, rd = 0;
  int            n_out = 0, n_in = 0;
  bit            lat_chk = 0;
  bit            rnd_ready = 0;
  int            stall_in = 0;

  function automatic longint ext(input logic [15:0] v, input int w, input logic sgn);
    if (sgn && v[w-1]) return longint'(v) - (longint'(1) << w);
    return longint'(v);
  endfunction

  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, b, acc,
                                          input logic [MW-1:0] m, input logic wide, sgn);
    logic [VW-1:0] r;
    longint s;
    r = acc;
    if (!wide) begin
      for (int i = 0; i < 2*NR; i++) if (m[i]) begin
        s = 0;
        for (int j = 0; j < 4; j++)
          s += ext({8'h00, a[32*i+8*j +: 8]}, 8, sgn) * ext({8'h00, b[32*i+8*j +: 8]}, 8, sgn);
        r[32*i +: 32] = acc[32*i +: 32] + s[31:0];
      end
    end else begin
      for (int k = 0; k < NR; k++) if (m[k]) begin
        s = 0;
        for (int j = 0; j < 4; j++)
          s += ext(a[64*k+16*j +: 16], 16, sgn) * ext(b[64*k+16*j +: 16], 16, sgn);
        r[64*k +: 64] = acc[64*k +: 64] + 64'(s);
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input logic [VW-1:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // called at a negedge; returns at the next negedge after acceptance
  task automatic send(input logic [VW-1:0] a, b, acc, input logic [MW-1:0] m,
                      input logic wide, sgn, input string tag);
    in_a = a; in_b = b; in_acc = acc; in_mask = m; in_wide = wide; in_signed = sgn;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      stall_in++;
      @(negedge clk); #1;
    end
    exp_q[wr[5:0]]  = model(a, b, acc, m, wide, sgn);
    acyc_q[wr[5:0]] = cyc;
    tag_q[wr[5:0]]  = tag;
    wr++; n_in++;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // consumer ready pattern
  always @(negedge clk) out_ready <= rnd_ready ? ($urandom_range(0, 9) < 6) : 1'b1;

  // output monitor
  bit            held = 0;
  logic [VW-1:0] held_res;
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      if (held) begin
        check(out_valid === 1'b1 && out_res === held_res, "R8 stalled result held", out_res, held_res);
      end
      if (out_valid && out_ready) begin
        if (rd == wr) check(1'b0, "R8 result with no accepted op", out_res, '0);
        else begin
          check(out_res === exp_q[rd[5:0]], {tag_q[rd[5:0]], " lane values"}, out_res, exp_q[rd[5:0]]);
          if (lat_chk)
            check(cyc - acyc_q[rd[5:0]] == 3, "R6 latency three cycles",
                  VW'(cyc - acyc_q[rd[5:0]]), VW'(3));
          rd++; n_out++;
        end
      end
      held = out_valid && !out_ready;
      held_res = out_res;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [7:0]  v8  [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
  logic [15:0] v16 [5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

  initial begin
    rst_n = 1'b1; in_valid = 1'b0; in_wide = 1'b0; in_signed = 1'b0;
    in_mask = '0; in_a = '0; in_b = '0; in_acc = '0; out_ready = 1'b1;
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R9 out_valid low in reset", VW'(out_valid), '0);
    check(in_ready === 1'b0, "R9 in_ready low in reset", VW'(in_ready), '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(in_ready === 1'b0, "R9 in_ready low after release", VW'(in_ready), '0);
    @(negedge clk); #1;
    check(in_ready === 1'b0, "R9 in_ready low after first edge", VW'(in_ready), '0);
    @(negedge clk); #1;
    check(in_ready === 1'b1, "R9 in_ready high after second edge", VW'(in_ready), VW'(1));
    @(negedge clk);

    // corner-value sweeps, both sizes and signedness
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 5; p++)
        for (int q = 0; q < 5; q++) begin
          send({(VW/8){v8[p]}}, {(VW/8){v8[q]}}, rvec(), '1, 1'b0, s[0], "R1 R3 byte sweep");
          send({(VW/16){v16[p]}}, {(VW/16){v16[q]}}, rvec(), '1, 1'b1, s[0], "R2 R3 half sweep");
        end

    // wrap and lane isolation
    send({(VW/8){8'h7F}}, {(VW/8){8'h7F}}, {(VW/32){32'h7FFF_FFFF}}, '1, 1'b0, 1'b1, "R4 byte positive wrap");
    send({(VW/8){8'h01}}, {(VW/8){8'h01}}, {(VW/64){64'h0000_0000_FFFF_FFFF}}, '1, 1'b0, 1'b0, "R4 byte no carry across lanes");
    send({(VW/8){8'h80}}, {(VW/8){8'h7F}}, {(VW/32){32'h8000_0000}}, '1, 1'b0, 1'b1, "R4 byte negative wrap");
    send({(VW/16){16'hFFFF}}, {(VW/16){16'hFFFF}}, {(VW/64){64'hFFFF_FFFF_FFFF_FFFF}}, '1, 1'b1, 1'b0, "R4 half wrap");

    // masks
    for (int m = 0; m < (1 << MW); m++) begin
      send(rvec(), rvec(), rvec(), MW'(m), 1'b0, m[0], "R5 byte mask");
      send(rvec(), rvec(), rvec(), MW'(m), 1'b1, m[1], "R5 half mask upper bits ignored");
    end
    idle();

    // random traffic under back-pressure
    rnd_ready = 1;
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0) idle();
      send(rvec(), rvec(), rvec(), MW'($urandom), $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, "R8 random stalled");
    end
    idle();
    rnd_ready = 0;
    repeat (10) @(negedge clk);

    // always-ready phase: latency and one per cycle
    lat_chk = 1;
    stall_in = 0;
    for (int n = 0; n < 100; n++)
      send(rvec(), rvec(), rvec(), MW'($urandom), n[0], n[1], "R7 back-to-back");
    idle();
    check(stall_in == 0, "R7 no input stall while ready", VW'(stall_in), '0);
    repeat (6) @(negedge clk);
    check(rd == wr && n_out == n_in, "R8 every op returned once", VW'(n_out), VW'(n_in));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule